// File: doc/BRIEF.md
# Page Translation Cache with Descriptor Checks

This block is a fully associative cache of page descriptors for one access class, either data or instruction. It turns a logical address into a physical address by matching the logical page number against the cached entries. Before it forwards a hit it checks the access rights the descriptor grants. These are the descriptor type, the supervisor-only flag and the write-protect flag. Any fault the block reports comes with a cause code.

When an access succeeds and that access newly sets the descriptor's used or modified flag, the block updates its cached copy. It also raises a one-cycle write-back request, so that the table in memory can be updated to match. On a miss the block stalls. It holds its miss output until a table walker outside the block presents the descriptor on the fill port, and the access completes on the next cycle. A control word switches translation on or off and selects 4 KiB or 8 KiB pages. A single strobe empties the whole cache.

Top module: `tc_translate_cache`

## Requirements
- R1: When control bit 15 is clear, an accepted request responds on the next cycle with the physical address equal to the logical address, with no fault and with the hit flag low.
- R2: Control bit 14 selects the page size: 0 means 4 KiB and 1 means 8 KiB. With 4 KiB pages the physical address is descriptor bits 31..12 joined to address bits 11..0. With 8 KiB pages it is descriptor bits 31..13 joined to address bits 12..0, and logical address bit 12 is not part of the page match.
- R3: A request that misses raises miss on the next cycle. Miss stays high until a fill is presented, and the response appears on the cycle after the fill. Requests made while miss is high are ignored.
- R4: A descriptor whose type field (bits 1..0) is 00 gives a fault with cause 1 and physical address 0. Such a descriptor is cached, so repeating the access hits and faults again without a new miss.
- R5: A user-mode access (supervisor input low) to a page whose bit 7 is set gives a fault with cause 2. The invalid-type fault takes priority over this one.
- R6: A write to a page whose bit 2 is set gives a fault with cause 3. A read of that page succeeds, and the privilege fault takes priority over this one.
- R7: A successful access sets the used flag (bit 3), and a successful write also sets the modified flag (bit 4). When either flag changes, wb_valid pulses for the response cycle and carries the logical page and the updated descriptor. There is no pulse when neither flag changes or when the access faults.
- R8: A successful response reports descriptor bits 6..5 as the cache mode. A hit served from the cache raises the hit flag.
- R9: The cache holds 64 entries. Fills replace entries in round-robin order, so the 65th distinct fill evicts the first page filled and leaves the second page resident.
- R10: A flush strobe invalidates every entry at once, so every page misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Logical address |
| req_write | input | 1 | 1 = write access |
| req_super | input | 1 | 1 = supervisor mode |
| ctrl | input | 16 | Control word: bit 15 enables translation, bit 14 selects the page size |
| flush_all | input | 1 | Invalidate every entry |
| fill_valid | input | 1 | Descriptor for the pending miss is present |
| fill_desc | input | 32 | Descriptor for the pending miss |
| miss | output | 1 | Waiting for a fill |
| resp_valid | output | 1 | Response present this cycle |
| resp_hit | output | 1 | Response served from a cached entry |
| phys_addr | output | 32 | Physical address (0 on a fault) |
| fault | output | 1 | Access refused |
| fault_cause | output | 2 | 0 none, 1 invalid type, 2 privilege, 3 write-protect |
| cache_mode | output | 2 | Cache mode of the page |
| wb_valid | output | 1 | Write back the updated descriptor |
| wb_page | output | 20 | Logical page number for the write-back |
| wb_desc | output | 32 | Updated descriptor |

## Verification
The translation path is tried with translation off, with 4 KiB pages and with 8 KiB pages. These runs separate a passthrough from a real remap, and they show whether address bit 12 takes part in the match. The rights checks use descriptors that carry one flag at a time and then flags together, under reads and writes in both modes. This exposes each fault cause and the priority among causes. Repeated accesses to the same page separate first-use and first-write updates from clean hits, so spurious or missing write-back pulses show up. A run of 65 fills, followed by probes of the first two pages, shows whether replacement follows round-robin order rather than some other policy. A flush followed by a probe shows whether every entry was cleared.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 12;
  localparam int VPN_W  = ADDR_W - OFS_W;

  typedef logic [VPN_W-1:0]  vpn_t;
  typedef logic [ADDR_W-1:0] desc_t;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_INVAL = 2'd1,
    CAUSE_PRIV  = 2'd2,
    CAUSE_WPROT = 2'd3
  } cause_e;

  localparam int BIT_WP   = 2;
  localparam int BIT_USED = 3;
  localparam int BIT_MOD  = 4;
  localparam int BIT_SUP  = 7;

  function automatic cause_e rights_check(desc_t d, logic wr, logic sup);
    if (d[1:0] == 2'b00)           return CAUSE_INVAL;
    if (d[BIT_SUP] && !sup)        return CAUSE_PRIV;
    if (d[BIT_WP] && wr)           return CAUSE_WPROT;
    return CAUSE_NONE;
  endfunction

  function automatic desc_t mark_access(desc_t d, logic wr);
    desc_t r;
    r = d;
    r[BIT_USED] = 1'b1;
    if (wr) r[BIT_MOD] = 1'b1;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] form_phys(desc_t d, logic [ADDR_W-1:0] a, logic big);
    logic [ADDR_W-1:0] p;
    p = {d[ADDR_W-1:OFS_W], a[OFS_W-1:0]};
    if (big) p[OFS_W] = a[OFS_W];
    return p;
  endfunction

  function automatic logic page_match(vpn_t tag, vpn_t vpn, logic big);
    if (big) return tag[VPN_W-1:1] == vpn[VPN_W-1:1];
    return tag == vpn;
  endfunction
endpackage

// File: rtl/tc_rr_ptr.sv
module tc_rr_ptr #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/tc_entry_array.sv
module tc_entry_array
  import tc_pkg::*;
#(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  vpn_t          wr_tag,
  input  desc_t         wr_desc,
  input  vpn_t          look_vpn,
  input  logic          big,
  output logic          hit,
  output logic [IW-1:0] hit_idx,
  output desc_t         hit_desc,
  output logic [N-1:0]  valid_vec
);
  vpn_t         tag_q  [N];
  desc_t        desc_q [N];
  logic [N-1:0] valid_q;
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_q[g] && page_match(tag_q[g], look_vpn, big);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  assign hit_desc  = desc_q[hit_idx];
  assign valid_vec = valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      desc_q[wr_idx] <= wr_desc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else begin
      if (flush) valid_q <= '0;
      if (wr_en) valid_q[wr_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/tc_translate_cache.sv
module tc_translate_cache
  import tc_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic        req_super,
  input  logic [15:0] ctrl,
  input  logic        flush_all,
  input  logic        fill_valid,
  input  logic [31:0] fill_desc,
  output logic        miss,
  output logic        resp_valid,
  output logic        resp_hit,
  output logic [31:0] phys_addr,
  output logic        fault,
  output logic [1:0]  fault_cause,
  output logic [1:0]  cache_mode,
  output logic        wb_valid,
  output logic [19:0] wb_page,
  output logic [31:0] wb_desc
);
  localparam int IW = $clog2(ENTRIES);

  logic tr_en, big;
  assign tr_en = ctrl[15];
  assign big   = ctrl[14];

  // pending miss
  logic [31:0] pend_addr;
  logic        pend_wr, pend_sup;

  // named internal events
  logic          accept, look_hit, hit_fire, miss_fire, fill_fire, arr_wr;
  logic [IW-1:0] hit_idx, rr_idx, wr_idx;
  desc_t         hit_desc;
  logic [ENTRIES-1:0] valid_vec;

  assign accept    = req_valid && !miss;
  assign hit_fire  = accept && tr_en && look_hit;
  assign miss_fire = accept && tr_en && !look_hit;
  assign fill_fire = miss && fill_valid;

  // evaluation source: fill completion or cache hit
  desc_t       ev_desc, ev_new;
  logic [31:0] ev_addr;
  logic        ev_wr, ev_sup, ev_dirty;
  cause_e      ev_cause;

  always_comb begin
    if (fill_fire) begin
      ev_desc = fill_desc;
      ev_addr = pend_addr;
      ev_wr   = pend_wr;
      ev_sup  = pend_sup;
    end else begin
      ev_desc = hit_desc;
      ev_addr = req_addr;
      ev_wr   = req_write;
      ev_sup  = req_super;
    end
    ev_cause = rights_check(ev_desc, ev_wr, ev_sup);
    ev_new   = (ev_cause == CAUSE_NONE) ? mark_access(ev_desc, ev_wr) : ev_desc;
    ev_dirty = (ev_new != ev_desc);
  end

  assign arr_wr = fill_fire || (hit_fire && ev_dirty);
  assign wr_idx = fill_fire ? rr_idx : hit_idx;

  tc_entry_array #(.N(ENTRIES)) u_arr (
    .clk(clk), .rst_n(rst_n), .flush(flush_all),
    .wr_en(arr_wr), .wr_idx(wr_idx), .wr_tag(ev_addr[31:12]), .wr_desc(ev_new),
    .look_vpn(req_addr[31:12]), .big(big),
    .hit(look_hit), .hit_idx(hit_idx), .hit_desc(hit_desc), .valid_vec(valid_vec)
  );

  tc_rr_ptr #(.N(ENTRIES)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv(fill_fire), .ptr(rr_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss        <= 1'b0;
      pend_addr   <= '0;
      pend_wr     <= 1'b0;
      pend_sup    <= 1'b0;
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      phys_addr   <= '0;
      fault       <= 1'b0;
      fault_cause <= 2'd0;
      cache_mode  <= 2'd0;
      wb_valid    <= 1'b0;
      wb_page     <= '0;
      wb_desc     <= '0;
    end else begin
      resp_valid <= 1'b0;
      wb_valid   <= 1'b0;
      if (accept && !tr_en) begin
        resp_valid  <= 1'b1;
        resp_hit    <= 1'b0;
        phys_addr   <= req_addr;
        fault       <= 1'b0;
        fault_cause <= 2'd0;
        cache_mode  <= 2'd0;
      end else if (miss_fire) begin
        miss      <= 1'b1;
        pend_addr <= req_addr;
        pend_wr   <= req_write;
        pend_sup  <= req_super;
      end else if (hit_fire || fill_fire) begin
        if (fill_fire) miss <= 1'b0;
        resp_valid  <= 1'b1;
        resp_hit    <= hit_fire;
        fault       <= (ev_cause != CAUSE_NONE);
        fault_cause <= ev_cause;
        phys_addr   <= (ev_cause == CAUSE_NONE) ? form_phys(ev_desc, ev_addr, big) : '0;
        cache_mode  <= (ev_cause == CAUSE_NONE) ? ev_desc[6:5] : 2'd0;
        wb_valid    <= ev_dirty;
        wb_page     <= ev_addr[31:12];
        wb_desc     <= ev_new;
      end
    end
  end
endmodule

// File: rtl/tc_translate_cache_chk.sv
module tc_translate_cache_chk #(
  parameter int ENTRIES = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [31:0]        req_addr,
  input logic [15:0]        ctrl,
  input logic               flush_all,
  input logic               fill_valid,
  input logic               miss,
  input logic               resp_valid,
  input logic [31:0]        phys_addr,
  input logic               fault,
  input logic [1:0]         fault_cause,
  input logic               wb_valid,
  input logic               arr_wr,
  input logic [ENTRIES-1:0] valid_vec
);
  // R1
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !miss && !ctrl[15]) |=> (resp_valid && !fault && phys_addr == $past(req_addr)));

  // R3
  miss_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !fill_valid) |=> miss);

  // R3
  fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && fill_valid) |=> (resp_valid && !miss));

  // R4
  cause_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (fault == (fault_cause != 2'd0)));

  // R7
  wb_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (resp_valid && !fault));

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !arr_wr) |=> (valid_vec == '0));
endmodule

bind tc_translate_cache tc_translate_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .ctrl(ctrl), .flush_all(flush_all), .fill_valid(fill_valid), .miss(miss),
  .resp_valid(resp_valid), .phys_addr(phys_addr), .fault(fault),
  .fault_cause(fault_cause), .wb_valid(wb_valid), .arr_wr(arr_wr),
  .valid_vec(valid_vec)
);

// File: tb/sim_tc_translate_cache.sv
module sim_tc_translate_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_super = 1'b0;
  logic [15:0] ctrl = '0;
  logic        flush_all = 1'b0;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_desc = '0;
  logic        miss, resp_valid, resp_hit, fault, wb_valid;
  logic [31:0] phys_addr, wb_desc;
  logic [1:0]  fault_cause, cache_mode;
  logic [19:0] wb_page;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  tc_translate_cache u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_super(req_super), .ctrl(ctrl),
    .flush_all(flush_all), .fill_valid(fill_valid), .fill_desc(fill_desc),
    .miss(miss), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .phys_addr(phys_addr), .fault(fault), .fault_cause(fault_cause),
    .cache_mode(cache_mode), .wb_valid(wb_valid), .wb_page(wb_page),
    .wb_desc(wb_desc)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what,
                    input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  // bench's own restatement of the address formation
  function automatic logic [31:0] want_phys(logic [31:0] d, logic [31:0] a, logic eight_k);
    if (eight_k) return {d[31:13], 13'd0} | (a & 32'h1FFF);
    return {d[31:12], 12'd0} | (a & 32'h0FFF);
  endfunction

  // issue one request; on return the cycle after it is being observed
  task automatic access(input logic [31:0] a, input logic wr, input logic sup);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_super = sup;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill(input logic [31:0] d);
    fill_valid = 1'b1; fill_desc = d;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
  endtask

  // access that misses then completes through a fill
  task automatic miss_fill(input logic [31:0] a, input logic wr, input logic sup,
                           input logic [31:0] d, input string req);
    access(a, wr, sup);
    eq(req, "miss raised", {31'd0, miss}, 32'd1);
    fill(d);
    eq(req, "resp after fill", {31'd0, resp_valid}, 32'd1);
  endtask

  task automatic t_reset();
    eq("R3", "reset miss", {31'd0, miss}, 32'd0);
    eq("R1", "reset resp_valid", {31'd0, resp_valid}, 32'd0);
    eq("R7", "reset wb_valid", {31'd0, wb_valid}, 32'd0);
  endtask

  task automatic t_passthru();
    ctrl = 16'h0000;
    access(32'h1234_5678, 1'b1, 1'b0);
    eq("R1", "resp_valid", {31'd0, resp_valid}, 32'd1);
    eq("R1", "phys", phys_addr, 32'h1234_5678);
    eq("R1", "fault", {31'd0, fault}, 32'd0);
    eq("R1", "hit", {31'd0, resp_hit}, 32'd0);
  endtask

  task automatic t_miss_4k();
    logic [31:0] d;
    ctrl = 16'h8000;
    d = 32'h0ABC_D000 | (32'd1 << 5) | 32'd1;
    access(32'h0040_1ABC, 1'b0, 1'b1);
    eq("R3", "miss raised", {31'd0, miss}, 32'd1);
    // stray request while waiting must be ignored
    access(32'h0099_9000, 1'b0, 1'b0);
    eq("R3", "miss held", {31'd0, miss}, 32'd1);
    eq("R3", "no resp while waiting", {31'd0, resp_valid}, 32'd0);
    fill(d);
    eq("R3", "resp after fill", {31'd0, resp_valid}, 32'd1);
    eq("R3", "miss cleared", {31'd0, miss}, 32'd0);
    eq("R2", "phys 4K", phys_addr, want_phys(d, 32'h0040_1ABC, 1'b0));
    eq("R8", "cache mode", {30'd0, cache_mode}, 32'd1);
    eq("R7", "wb on first use", {31'd0, wb_valid}, 32'd1);
    eq("R7", "wb desc used", wb_desc, d | 32'h8);
    eq("R7", "wb page", {12'd0, wb_page}, 32'h00401);
    @(negedge clk);
    eq("R7", "wb one cycle", {31'd0, wb_valid}, 32'd0);
    // read hit: flags already set
    access(32'h0040_1004, 1'b0, 1'b1);
    eq("R8", "hit flag", {31'd0, resp_hit}, 32'd1);
    eq("R2", "hit phys", phys_addr, want_phys(d, 32'h0040_1004, 1'b0));
    eq("R7", "no wb clean read", {31'd0, wb_valid}, 32'd0);
    // first write sets modified
    access(32'h0040_1008, 1'b1, 1'b1);
    eq("R7", "wb first write", {31'd0, wb_valid}, 32'd1);
    eq("R7", "wb desc modified", wb_desc, d | 32'h18);
    access(32'h0040_100C, 1'b1, 1'b0);
    eq("R7", "no wb second write", {31'd0, wb_valid}, 32'd0);
    eq("R7", "second write ok", {31'd0, fault}, 32'd0);
  endtask

  task automatic t_wprot();
    logic [31:0] d;
    d = 32'h0555_0000 | 32'h4 | 32'h1;
    miss_fill(32'h0050_0010, 1'b0, 1'b0, d, "R6");
    eq("R6", "read ok", {31'd0, fault}, 32'd0);
    access(32'h0050_0020, 1'b1, 1'b0);
    eq("R6", "write cause", {30'd0, fault_cause}, 32'd3);
    eq("R6", "fault phys", phys_addr, 32'd0);
    eq("R7", "no wb on fault", {31'd0, wb_valid}, 32'd0);
  endtask

  task automatic t_priv();
    logic [31:0] d;
    d = 32'h0666_0000 | 32'h80 | 32'h4 | 32'h1;
    miss_fill(32'h0060_0000, 1'b1, 1'b0, d, "R5");
    eq("R5", "user write cause priv over wprot", {30'd0, fault_cause}, 32'd2);
    access(32'h0060_0040, 1'b0, 1'b1);
    eq("R5", "super read ok", {31'd0, fault}, 32'd0);
    eq("R5", "super phys", phys_addr, want_phys(d, 32'h0060_0040, 1'b0));
  endtask

  task automatic t_invalid();
    logic [31:0] d;
    d = 32'h0777_0000 | 32'h80;
    miss_fill(32'h0070_0000, 1'b0, 1'b0, d, "R4");
    eq("R4", "invalid cause over priv", {30'd0, fault_cause}, 32'd1);
    eq("R4", "fault", {31'd0, fault}, 32'd1);
    access(32'h0070_0100, 1'b0, 1'b1);
    eq("R4", "cached invalid no miss", {31'd0, miss}, 32'd0);
    eq("R4", "cached invalid faults", {30'd0, fault_cause}, 32'd1);
  endtask

  task automatic t_flush_8k();
    logic [31:0] d;
    do_flush();
    access(32'h0040_1000, 1'b0, 1'b1);
    eq("R10", "miss after flush", {31'd0, miss}, 32'd1);
    fill(32'h0ABC_D001);
    ctrl = 16'hC000;
    d = 32'h1230_0001;
    miss_fill(32'h0080_0123, 1'b0, 1'b1, d, "R2");
    eq("R2", "phys 8K even", phys_addr, want_phys(d, 32'h0080_0123, 1'b1));
    access(32'h0080_1456, 1'b0, 1'b1);
    eq("R2", "8K odd half hits", {31'd0, resp_hit}, 32'd1);
    eq("R2", "phys 8K odd", phys_addr, want_phys(d, 32'h0080_1456, 1'b1));
  endtask

  task automatic t_round_robin();
    ctrl = 16'h8000;
    do_flush();
    for (int i = 0; i < 65; i++) begin
      access(32'h0100_0000 + (i << 12), 1'b0, 1'b1);
      fill(32'h2000_0001 + (i << 12));
    end
    access(32'h0100_1000, 1'b0, 1'b1);
    eq("R9", "second page resident", {31'd0, resp_hit}, 32'd1);
    eq("R9", "second page no miss", {31'd0, miss}, 32'd0);
    access(32'h0100_0000, 1'b0, 1'b1);
    eq("R9", "first page evicted", {31'd0, miss}, 32'd1);
    fill(32'h2000_0001);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthru();
    t_miss_4k();
    t_wprot();
    t_priv();
    t_invalid();
    t_flush_8k();
    t_round_robin();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule